// File: doc/BRIEF.md
# End-of-Life Alarm Indicator Controller

This block produces the visible and audible alarm of a protection device that has reached end of life. It does nothing until an end-of-life request arrives from the self-test logic. The request latches the alarm. The block then fires the thyristor gate for a burst of positive half cycles of the mains. After the burst it blinks the indicator LED and fires the gate again for one positive half cycle at a long fixed interval. It also requests a fresh self-test once per second. Both the LED and the gate are qualified by a half-cycle polarity flag, so neither ever draws current during a negative half cycle.

The latched alarm is cleared in two ways. A passing self-test clears it, and so does a detected ground fault, which is what a press of the manual test button produces. In either case the block returns to the state it has after power-on and can be latched again. All timing comes from a 1 ms tick, so the intervals are parameters expressed in ticks.

States: `ST_IDLE` (quiet), `ST_BURST` (initial gate burst), `ST_ALARM` (blinking, waiting for the next periodic firing), `ST_ARM` (periodic interval elapsed, waiting for a positive half cycle to begin), `ST_FIRE` (gate driven for that half cycle). Transitions: IDLE→BURST on request; BURST→ALARM at the end of the last burst half cycle; ALARM→ARM when the firing interval elapses; ARM→FIRE when a positive half cycle begins; FIRE→ALARM when it ends; any latched state→IDLE on a pass strobe or ground-fault flag.

Top module: `eol_alarm_ctrl`

## Requirements
- R1: After reset, and while not latched, `led_on`, `scr_gate` and `st_trigger` stay low. `st_pass` and `gf_detect` have no effect in this state.
- R2: A high `eol_req` while not latched starts the burst. In the burst, `scr_gate` follows `pos_half` (1 = positive half cycle) until BURST_HALVES positive half cycles have ended, and `led_on` stays low.
- R3: After the burst, the LED blinks with BLINK_MS ticks on and BLINK_MS ticks off, starting in the on phase. `led_on` is high only when the blink is in its on phase and `pos_half` is 1.
- R4: After the burst, once every SCR_PERIOD_MS ticks, `scr_gate` is driven for the whole of the next positive half cycle that begins.
- R5: `scr_gate` is never high while `pos_half` is 0.
- R6: While latched, counting from the start of the burst, `st_trigger` gives a one-cycle pulse every ST_PERIOD_MS ticks.
- R7: A high `st_pass` while latched returns the block to its power-on state. A later `eol_req` runs the full burst again.
- R8: A high `gf_detect` while latched also returns the block to its power-on state.
- R9: `eol_req` while latched is ignored. The alarm does not restart.
- R10: All intervals advance only on cycles with `tick_ms` high. Without ticks, no `st_trigger` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eol_req | input | 1 | Request to latch the end-of-life alarm |
| pos_half | input | 1 | Mains polarity: 1 in positive half cycle |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| st_pass | input | 1 | Strobe: a self-test has passed |
| gf_detect | input | 1 | Ground fault detected |
| led_on | output | 1 | LED drive |
| scr_gate | output | 1 | Thyristor gate drive |
| st_trigger | output | 1 | One-cycle self-test request |

## Verification
The bench builds the block with BURST_HALVES=4, BLINK_MS=3, SCR_PERIOD_MS=40 and ST_PERIOD_MS=10, and drives a tick on every clock. It also drives a polarity square wave with five cycles per half. With these values the firing interval and the trigger interval are whole multiples of the mains period, so the spacing between periodic firings and between trigger pulses is exact and can be compared cycle for cycle. A window of a few hundred cycles is then enough to cover many blink phases, several periodic firings, both ways of clearing the alarm and the repeated burst after a clear. Holding the polarity high for a stretch shows the bare blink cadence. Stopping the tick shows that every interval freezes.

// File: rtl/eol_alarm_pkg.sv
package eol_alarm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BURST = 3'd1,
        ST_ALARM = 3'd2,
        ST_ARM   = 3'd3,
        ST_FIRE  = 3'd4
    } eol_state_e;
endpackage

// File: rtl/eol_tick_div.sv
// Tick-driven interval counter: wrap pulses on the tick that completes PERIOD.
module eol_tick_div #(
    parameter int PERIOD = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic wrap
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    assign wrap = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/eol_alarm_fsm.sv
// Alarm sequencer: burst, blink, periodic firing and clearing.
module eol_alarm_fsm
    import eol_alarm_pkg::*;
#(
    parameter int BURST_HALVES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eol_req,
    input  logic       pos_half,
    input  logic       pos_rise,
    input  logic       pos_fall,
    input  logic       clear,
    input  logic       blink_wrap,
    input  logic       scr_wrap,
    output eol_state_e state,
    output logic       led_on,
    output logic       scr_gate
);
    localparam int BW = $clog2(BURST_HALVES + 1);
    localparam logic [BW-1:0] LAST_HALF = BW'(BURST_HALVES - 1);

    eol_state_e state_q, state_d;
    logic [BW-1:0] half_cnt;
    logic          blink_on;
    logic          alarm_phase;

    assign state       = state_q;
    assign alarm_phase = (state_q == ST_ALARM) || (state_q == ST_ARM) || (state_q == ST_FIRE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (eol_req) state_d = ST_BURST;
            ST_BURST: if (clear) state_d = ST_IDLE;
                      else if (pos_fall && half_cnt == LAST_HALF) state_d = ST_ALARM;
            ST_ALARM: if (clear) state_d = ST_IDLE;
                      else if (scr_wrap) state_d = ST_ARM;
            ST_ARM:   if (clear) state_d = ST_IDLE;
                      else if (pos_rise) state_d = ST_FIRE;
            ST_FIRE:  if (clear) state_d = ST_IDLE;
                      else if (pos_fall) state_d = ST_ALARM;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            half_cnt <= '0;
            blink_on <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q != ST_BURST) begin
                half_cnt <= '0;
            end else if (pos_fall) begin
                half_cnt <= half_cnt + BW'(1);
            end
            if (!alarm_phase) begin
                blink_on <= 1'b1;
            end else if (blink_wrap) begin
                blink_on <= !blink_on;
            end
        end
    end

    // outputs, all qualified by the positive half cycle
    always_comb begin
        scr_gate = 1'b0;
        led_on   = alarm_phase && blink_on && pos_half;
        unique case (state_q)
            ST_BURST: scr_gate = pos_half;
            ST_ARM:   scr_gate = pos_rise;
            ST_FIRE:  scr_gate = pos_half;
            default:  scr_gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/eol_alarm_ctrl.sv
// End-of-life alarm indicator controller (top).
module eol_alarm_ctrl
    import eol_alarm_pkg::*;
#(
    parameter int BURST_HALVES  = 4,
    parameter int BLINK_MS      = 125,
    parameter int SCR_PERIOD_MS = 4500,
    parameter int ST_PERIOD_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eol_req,
    input  logic pos_half,
    input  logic tick_ms,
    input  logic st_pass,
    input  logic gf_detect,
    output logic led_on,
    output logic scr_gate,
    output logic st_trigger
);
    eol_state_e state;
    logic pos_q, pos_rise, pos_fall, clear;
    logic latched, alarm_run;
    logic blink_wrap, scr_wrap, st_wrap;

    assign pos_rise  = pos_half && !pos_q;
    assign pos_fall  = !pos_half && pos_q;
    assign clear     = st_pass || gf_detect;
    assign latched   = (state != ST_IDLE);
    assign alarm_run = latched && (state != ST_BURST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q      <= 1'b0;
            st_trigger <= 1'b0;
        end else begin
            pos_q      <= pos_half;
            st_trigger <= st_wrap && !clear;
        end
    end

    eol_tick_div #(.PERIOD(BLINK_MS)) u_blink_div (
        .clk(clk), .rst_n(rst_n), .run(alarm_run), .tick(tick_ms), .wrap(blink_wrap)
    );

    eol_tick_div #(.PERIOD(SCR_PERIOD_MS)) u_scr_div (
        .clk(clk), .rst_n(rst_n), .run(alarm_run), .tick(tick_ms), .wrap(scr_wrap)
    );

    eol_tick_div #(.PERIOD(ST_PERIOD_MS)) u_st_div (
        .clk(clk), .rst_n(rst_n), .run(latched), .tick(tick_ms), .wrap(st_wrap)
    );

    eol_alarm_fsm #(.BURST_HALVES(BURST_HALVES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .eol_req(eol_req), .pos_half(pos_half),
        .pos_rise(pos_rise), .pos_fall(pos_fall), .clear(clear),
        .blink_wrap(blink_wrap), .scr_wrap(scr_wrap),
        .state(state), .led_on(led_on), .scr_gate(scr_gate)
    );
endmodule

// File: rtl/eol_alarm_chk.sv
// Property checker attached to the top module.
module eol_alarm_chk
    import eol_alarm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pos_half,
    input logic       tick_ms,
    input logic       st_pass,
    input logic       gf_detect,
    input logic       led_on,
    input logic       scr_gate,
    input logic       st_trigger,
    input eol_state_e state
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scr_gate && !led_on)); // R1
    AST_BURST_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST) |-> !led_on); // R2
    AST_LED_POS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        led_on |-> pos_half); // R3
    AST_SCR_POS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        scr_gate |-> pos_half); // R5
    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_trigger |=> !st_trigger); // R6
    AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && st_pass) |=> (state == ST_IDLE)); // R7
    AST_CLEAR_GF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && gf_detect) |=> (state == ST_IDLE)); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !st_pass && !gf_detect) |=> (state != ST_IDLE)); // R9
    AST_TRIG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_trigger |-> $past(tick_ms)); // R10
endmodule

bind eol_alarm_ctrl eol_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pos_half(pos_half), .tick_ms(tick_ms),
    .st_pass(st_pass), .gf_detect(gf_detect), .led_on(led_on),
    .scr_gate(scr_gate), .st_trigger(st_trigger), .state(state)
);

// File: tb/tb_eol_alarm_ctrl.sv
module tb_eol_alarm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BURST = 4;
    localparam int BLINK = 3;
    localparam int SCRP  = 40;
    localparam int STP   = 10;
    localparam int H     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eol_req = 1'b0, pos_half = 1'b0, tick_ms = 1'b1;
    logic st_pass = 1'b0, gf_detect = 1'b0;
    logic led_on, scr_gate, st_trigger;

    int n_chk = 0, n_bad = 0;
    int ph = 0;
    bit hold_pos = 1'b0;

    int cyc = 0;
    int scr_rises, scr_gap, scr_w_bad, scr_rise_t;
    int led_hi, led_tog, led_gap_bad, led_tog_t;
    int st_cnt, st_gap, st_w_bad, st_t;
    int viol_scr = 0, viol_led = 0;
    logic scr_p = 1'b0, led_p = 1'b0, st_p = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eol_alarm_ctrl #(
        .BURST_HALVES(BURST), .BLINK_MS(BLINK), .SCR_PERIOD_MS(SCRP), .ST_PERIOD_MS(STP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .eol_req(eol_req), .pos_half(pos_half),
        .tick_ms(tick_ms), .st_pass(st_pass), .gf_detect(gf_detect),
        .led_on(led_on), .scr_gate(scr_gate), .st_trigger(st_trigger)
    );

    // mains polarity source: H cycles low, H cycles high
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (hold_pos) begin
                pos_half = 1'b1;
            end else begin
                ph = (ph + 1) % (2 * H);
                pos_half = (ph >= H);
            end
        end
    end

    task automatic clear_stats();
        scr_rises = 0; scr_gap = -1; scr_w_bad = 0; scr_rise_t = -1;
        led_hi = 0; led_tog = 0; led_gap_bad = 0; led_tog_t = -1;
        st_cnt = 0; st_gap = -1; st_w_bad = 0; st_t = -1;
    endtask

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scr_gate && !pos_half) viol_scr++;
            if (led_on && !pos_half) viol_led++;
            if (scr_gate && !scr_p) begin
                scr_rises++;
                if (scr_rise_t >= 0) scr_gap = cyc - scr_rise_t;
                scr_rise_t = cyc;
            end
            if (!scr_gate && scr_p && scr_rise_t >= 0 && (cyc - scr_rise_t) != H) scr_w_bad++;
            if (led_on) led_hi++;
            if (led_on != led_p) begin
                led_tog++;
                if (led_tog_t >= 0 && (cyc - led_tog_t) != BLINK) led_gap_bad++;
                led_tog_t = cyc;
            end
            if (st_trigger) begin
                if (st_p) st_w_bad++;
                else begin
                    st_cnt++;
                    if (st_t >= 0) st_gap = cyc - st_t;
                    st_t = cyc;
                end
            end
        end
        scr_p = scr_gate; led_p = led_on; st_p = st_trigger;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(posedge clk); #1 sig = 1'b1;
        @(posedge clk); #1 sig = 1'b0;
    endtask

    // latch the alarm during a negative half cycle, then count burst firings
    task automatic enter_and_measure_burst(input string req);
        do @(negedge clk); while (!(ph < H - 1));
        @(posedge clk); #1 eol_req = 1'b1;
        clear_stats();
        @(posedge clk); #1 eol_req = 1'b0;
        for (int i = 0; i < 400 && led_hi == 0; i++) @(negedge clk);
        check(req, scr_rises, BURST);
        check(req, scr_w_bad, 0);
    endtask

    task automatic quiet_window(input string req);
        cycles(2);
        clear_stats();
        cycles(100);
        check(req, scr_rises, 0);
        check(req, led_hi, 0);
        check(req, st_cnt, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        clear_stats();
        cycles(3);
        check("R1 reset led", int'(led_on), 0);
        check("R1 reset scr", int'(scr_gate), 0);
        check("R1 reset trig", int'(st_trigger), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: idle ignores pass strobe and ground fault
        clear_stats();
        pulse(st_pass);
        pulse(gf_detect);
        cycles(40);
        check("R1 idle scr", scr_rises, 0);
        check("R1 idle led", led_hi, 0);
        check("R1 idle trig", st_cnt, 0);

        // R2: burst of positive half cycles, LED dark
        enter_and_measure_burst("R2");

        // R4 / R6: periodic firing and trigger cadence
        cycles(20);
        clear_stats();
        cycles(200);
        check("R4 fire count", scr_rises, 200 / SCRP);
        check("R4 fire spacing", scr_gap, SCRP);
        check("R4 fire width", scr_w_bad, 0);
        check("R6 trig count", st_cnt, 200 / STP);
        check("R6 trig spacing", st_gap, STP);
        check("R6 trig width", st_w_bad, 0);

        // R9: a new request while latched does not restart the burst
        pulse(eol_req);
        clear_stats();
        cycles(20);
        check("R9 still blinking", int'(led_hi > 0), 1);

        // R3: blink cadence with the polarity held positive
        hold_pos = 1'b1;
        cycles(3);
        clear_stats();
        cycles(30);
        check("R3 blink toggles", led_tog, 30 / BLINK);
        check("R3 blink spacing", led_gap_bad, 0);
        hold_pos = 1'b0;

        // R10: without ticks nothing is timed
        @(posedge clk); #1 tick_ms = 1'b0;
        cycles(2);
        clear_stats();
        cycles(80);
        check("R10 frozen trig", st_cnt, 0);
        @(posedge clk); #1 tick_ms = 1'b1;
        cycles(1);
        clear_stats();
        cycles(40);
        check("R10 resumed trig", st_cnt, 40 / STP);

        // R7: pass strobe clears, then a full burst again
        pulse(st_pass);
        quiet_window("R7 cleared");
        enter_and_measure_burst("R7 reburst");

        // R8: ground fault clears
        cycles(30);
        pulse(gf_detect);
        quiet_window("R8 cleared");

        check("R5 gate in negative half", viol_scr, 0);
        check("R3 led in negative half", viol_led, 0);

        summary();
        $finish;
    end
endmodule